// File: doc/BRIEF.md
# Single-Shot Pulse Width Capture Timer

This block measures the width of one pulse on an external input. Software first writes a preload value. Writing the preload while the block is idle also seeds the counter. Software then writes the control register with the capture mode selected, the polarity chosen and the enable bit set. The block then waits. Nothing counts until the chosen start edge arrives on the input. From that edge on, a prescaler produces one tick every `PRESC_DIV` clocks, and the 16-bit counter advances by one on each tick. When the input goes back to its idle level, the hardware clears the enable bit and the counter freezes. Software reads the count from the read port; it is the pulse length in ticks, added to the seed value.

If the counter passes its maximum while counting, it reloads from the preload register and keeps going. At the same moment it raises a sticky interrupt flag, provided the interrupt enable input is high. The flag stays set until software pulses the clear strobe. Once the enable bit has cleared itself, the block ignores the input until software enables it again. Each enable therefore gives exactly one measurement.

Top module: `pwc_timer`

## Requirements
- R1: After reset, the control readback is 0x00, the counter reads 0x0000 and the interrupt output is low.
- R2: The control register uses these bit positions. Bits 7:6 are the mode field, and the value 2'b11 selects capture. Bit 4 is the enable bit. Bit 3 selects the polarity. All other bits read back as 0.
- R3: Setting the enable bit does not start counting. While no start edge arrives, the counter keeps its value and the enable bit stays set.
- R4: With polarity 0, counting starts on a falling edge of the input and stops on the next rising edge. With polarity 1, counting starts on a rising edge and stops on the next falling edge.
- R5: The prescaler restarts at each start edge. The final count is the seed value plus floor(L / PRESC_DIV), where L is the pulse length in clock cycles. The input passes through a synchronizer of `SYNC_STAGES` flops.
- R6: When the stop edge arrives, the hardware clears the enable bit and the counter holds the result.
- R7: Once the enable bit has cleared, further pulses on the input leave the counter unchanged.
- R8: A tick at count 0xFFFF loads the preload register into the counter, and counting continues.
- R9: An overflow while `irq_en`=1 sets the `irq` flag, which stays set until `irq_clr` is pulsed. An overflow while `irq_en`=0 does not set the flag.
- R10: A pulse starts no capture unless the mode field is 2'b11 and `pin_is_input` is 1.
- R11: A preload write while the enable bit is 0 also loads the counter. A preload write while the enable bit is 1 leaves the counter unchanged.
- R12: A control write with the enable bit at 0 stops a capture that is in progress. The counter then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| preload_wr | input | 1 | Preload register write strobe |
| preload_wdata | input | 16 | Preload write data |
| cnt_rdata | output | 16 | Counter readback |
| irq_en | input | 1 | Overflow interrupt enable |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| irq | output | 1 | Sticky overflow interrupt flag |
| cap_in | input | 1 | External pulse input (asynchronous) |
| pin_is_input | input | 1 | The pin is configured as an input |

## Verification
Captures run with both polarities. Some pulses are long and some are shorter than one prescaler period, which shows that partial ticks are dropped. Several seed values are used: one far from the top of the range, one a step below 0xFFFF, and 0xFFFF itself. These show the difference between plain counting, a single reload and a reload on every tick. Pulses that arrive when capture is not allowed must leave the counter unchanged. This covers pulses after the self-clear, pulses in the wrong mode, and pulses while the pin is not an input. A pulse cut short by a software disable must freeze the count at the point of the write.

// File: rtl/pwc_pkg.sv
// Shared constants for the pulse width capture timer.
package pwc_pkg;
    localparam logic [1:0] MODE_CAPTURE = 2'b11;
    localparam int CTRL_EN_BIT   = 4;
    localparam int CTRL_EDGE_BIT = 3;
endpackage

// File: rtl/pwc_edge_det.sv
// Synchronizes an asynchronous input and flags its rising and falling edges.
// Assumes: the input is stable for at least STAGES+1 clocks between edges.
module pwc_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronized sample, used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pwc_prescaler.sv
// Emits one tick every DIV clocks while run is high; restarts when run is low.
// Assumes: DIV >= 2.
module pwc_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    assign tick = run && (pcnt_q == LAST);

    // Phase counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt_q <= '0;
        else if (tick)      pcnt_q <= '0;
        else                pcnt_q <= pcnt_q + 1'b1;
    end

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/pwc_counter.sv
// Up-counter with direct load and reload-from-preload on overflow.
// Assumes: load and inc may coincide; load wins.
module pwc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] preload,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = '1;

    assign ovf = inc && !load && (cnt == MAXV);

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (load) cnt <= load_val;
        else if (ovf)  cnt <= preload;
        else if (inc)  cnt <= cnt + 1'b1;
    end

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt == $past(preload));
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/pwc_timer.sv
// Single-shot pulse width capture timer: control register, capture state,
// prescaled 16-bit counter with preload reload, sticky overflow interrupt.
// Assumes: cap_in is asynchronous; all software strobes are one clock wide.
module pwc_timer #(
    parameter int CNT_W       = 16,
    parameter int PRESC_DIV   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    input  logic             preload_wr,
    input  logic [CNT_W-1:0] preload_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             irq,
    input  logic             cap_in,
    input  logic             pin_is_input
);
    import pwc_pkg::*;

    logic [1:0]       mode_q;
    logic             en_q;
    logic             pol_q;
    logic             active_q;
    logic             irq_q;
    logic [CNT_W-1:0] preload_q;
    logic             rise, fall, start_edge, stop_edge, capture_ok;
    logic             tick, ovf;

    pwc_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall));

    pwc_prescaler #(.DIV(PRESC_DIV)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(active_q), .tick(tick));

    pwc_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .inc(tick),
        .load(preload_wr && !en_q), .load_val(preload_wdata),
        .preload(preload_q), .cnt(cnt_rdata), .ovf(ovf));

    assign start_edge = pol_q ? rise : fall;
    assign stop_edge  = pol_q ? fall : rise;
    assign capture_ok = (mode_q == MODE_CAPTURE) && pin_is_input;

    // Control register with hardware self-clear of the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= ctrl_wdata[7:6];
            en_q   <= ctrl_wdata[CTRL_EN_BIT];
            pol_q  <= ctrl_wdata[CTRL_EDGE_BIT];
        end else if (active_q && stop_edge) begin
            en_q   <= 1'b0;
        end
    end

    // Capture phase: armed -> counting on start edge, back on stop edge.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr)                          active_q <= 1'b0;
        else if (active_q && stop_edge)                 active_q <= 1'b0;
        else if (en_q && start_edge && capture_ok)      active_q <= 1'b1;
    end

    // Preload register.
    always_ff @(posedge clk) begin
        if (!rst_n)          preload_q <= '0;
        else if (preload_wr) preload_q <= preload_wdata;
    end

    // Sticky interrupt flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              irq_q <= 1'b0;
        else if (ovf && irq_en)  irq_q <= 1'b1;
        else if (irq_clr)        irq_q <= 1'b0;
    end

    assign irq = irq_q;
    assign ctrl_rdata = {mode_q, 1'b0, en_q, pol_q, 3'b000};

    // R6
    active_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> en_q);
    // R6
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && stop_edge && !ctrl_wr) |=> (!en_q && !active_q));
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(irq_en));
    // R10
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !capture_ok) |=> !active_q);
endmodule

// File: tb/pwc_timer_tb.sv
module pwc_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        preload_wr = 1'b0;
    logic [15:0] preload_wdata = '0;
    logic [15:0] cnt_rdata;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        cap_in = 1'b1;
    logic        pin_is_input = 1'b1;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwc_timer dut_i (.*);

    // {polarity, seed, pulse length, expected count, expected irq}, DIV=4
    localparam logic [49:0] VEC [5] = '{
        {1'b0, 16'h0000, 16'd40, 16'h000A, 1'b0},
        {1'b1, 16'h1000, 16'd23, 16'h1005, 1'b0},
        {1'b0, 16'hFFFE, 16'd16, 16'hFFFE, 1'b1},
        {1'b1, 16'h0100, 16'd3,  16'h0100, 1'b0},
        {1'b0, 16'hFFFF, 16'd8,  16'hFFFF, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0;
    endtask

    task automatic wr_pre(input logic [15:0] v);
        preload_wdata = v; preload_wr = 1'b1; cyc(1); preload_wr = 1'b0;
    endtask

    task automatic pulse(input logic pol, input int len);
        cap_in = ~pol; cyc(len); cap_in = pol ^ 1'b1;
        cap_in = ~cap_in;
        cap_in = ~pol;
    endtask

    // Drive the active level for len cycles, then return to idle.
    task automatic send(input logic pol, input int len);
        cap_in = pol; cyc(len); cap_in = ~pol; cyc(8);
    endtask

    task automatic idle_to(input logic pol);
        cap_in = ~pol; cyc(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(3); rst_n = 1'b1; cyc(1);
        // R1 reset state
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 cnt", cnt_rdata, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        // R2 field layout readback
        wr_ctrl(8'hEF); cyc(1);
        chk("R2 readback", ctrl_rdata, 8'hC8);
        irq_en = 1'b1;
        // Vector table: R4 R5 R6 R8 R9
        for (int i = 0; i < 5; i++) begin
            idle_to(VEC[i][49]);
            wr_pre(VEC[i][48:33]);
            wr_ctrl(8'hD0 | (8'(VEC[i][49]) << 3)); cyc(3);
            send(VEC[i][49], int'(VEC[i][32:17]));
            chk("R4/R5/R8 count", cnt_rdata, VEC[i][16:1]);
            chk("R6 enable cleared", ctrl_rdata[4], 1'b0);
            chk("R9 irq", irq, VEC[i][0]);
            irq_clr = 1'b1; cyc(1); irq_clr = 1'b0; cyc(1);
        end
        // R9 flag sticky until clear, suppressed when disabled
        idle_to(1'b0); wr_pre(16'hFFFF);
        wr_ctrl(8'hD0); cyc(3); send(1'b0, 8); cyc(20);
        chk("R9 sticky", irq, 1'b1);
        irq_clr = 1'b1; cyc(1); irq_clr = 1'b0;
        chk("R9 cleared", irq, 1'b0);
        irq_en = 1'b0; wr_pre(16'hFFFF);
        wr_ctrl(8'hD0); cyc(3); send(1'b0, 8);
        chk("R9 suppressed", irq, 1'b0);
        irq_en = 1'b1;
        // R7 pulses after self-clear ignored
        wr_pre(16'h0020); send(1'b0, 40);
        chk("R7 ignored", cnt_rdata, 16'h0020);
        // R3 armed without edge
        wr_ctrl(8'hD0); cyc(30);
        chk("R3 no count", cnt_rdata, 16'h0020);
        chk("R3 still armed", ctrl_rdata[4], 1'b1);
        // R11 preload write while enabled leaves counter
        wr_pre(16'h0555); cyc(1);
        chk("R11 enabled write", cnt_rdata, 16'h0020);
        // R12 software abort mid-pulse: 20 cycles -> 5 ticks, then freeze
        cap_in = 1'b0; cyc(3 + 20); wr_ctrl(8'hC0); cyc(20); cap_in = 1'b1; cyc(8);
        chk("R12 abort", cnt_rdata, 16'h0025);
        // R10 wrong mode
        wr_pre(16'h0030); wr_ctrl(8'h50); cyc(3); send(1'b0, 40);
        chk("R10 mode", cnt_rdata, 16'h0030);
        chk("R10 armed kept", ctrl_rdata[4], 1'b1);
        // R10 pin not input
        wr_ctrl(8'h00); wr_pre(16'h0040); pin_is_input = 1'b0;
        wr_ctrl(8'hD0); cyc(3); send(1'b0, 40);
        chk("R10 pin", cnt_rdata, 16'h0040);
        // R11 idle preload write seeds counter
        wr_ctrl(8'h00); pin_is_input = 1'b1; wr_pre(16'h1234); cyc(1);
        chk("R11 idle write", cnt_rdata, 16'h1234);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule